// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received frame is kept, judging only its 48-bit destination MAC address. Two mechanisms run side by side: a bank of sixteen exact-match address entries, each with its own valid flag, and a 4096-bit multicast hash table. The hash index is a 12-bit window of the upper address bytes. A 2-bit mode input picks one of four window positions. The all-ones broadcast address is always kept.

Software fills the entries and the table through a plain word-wide write port: one 32-bit word per write, with no read-back. The receive path presents a destination address with a one-cycle strobe. Exactly two clock cycles later it gets a one-cycle result-valid pulse together with the accept decision. A lookup always sees the tables as they stood in the cycle of its strobe.

The address is carried as a 48-bit vector in which byte k of the address occupies bits [8k+7:8k]. Byte 0 is the first byte on the wire, so bit 0 is the group (multicast) bit, and bit 32 is the least significant bit of byte 4.

Top module: `rx_addr_filter`

## Requirements
- R1: The bank has 16 entries. A write with cfg_wr_addr[7]=0 and cfg_wr_addr[6:5]=0 targets entry cfg_wr_addr[4:1]. cfg_wr_addr[0]=0 selects the low word: address bytes 0..3, with byte 0 in data bits [7:0]. cfg_wr_addr[0]=1 selects the high word: byte 4 in bits [7:0], byte 5 in bits [15:8], and the valid flag in bit 31. A write with cfg_wr_addr[7]=0 and a nonzero cfg_wr_addr[6:5] changes nothing.
- R2: An address is accepted when some entry has its valid flag set and holds all 48 address bits. Any entry index can provide the match. An entry whose valid flag is 0 never matches.
- R3: Writing an entry's high word with the valid flag 0 stops that entry matching from the next lookup onward, even while its low word still holds the address.
- R4: The hash table has 128 words of 32 bits. A write with cfg_wr_addr[7]=1 replaces the whole word cfg_wr_addr[6:0]. Table bit h lives in word h[11:5] at bit h[4:0].
- R5: mc_type selects the 12-bit hash window: 0 uses address bits [47:36], 1 uses [46:35], 2 uses [45:34], and 3 uses [43:32]. With mode 0, byte 4 = 0x35 and byte 5 = 0x56 give hash 0x563, which is word 0x2B, bit 3.
- R6: The hash path accepts an address only when lk_addr[0] is 1 and the selected table bit is 1. For a unicast address (lk_addr[0]=0), the table has no effect.
- R7: The all-ones address is accepted whatever the entries and the table hold.
- R8: A strobe on lk_stb in one cycle gives res_vld high for exactly one cycle, two rising edges later. res_vld is low in every other cycle, and res_acc is low whenever res_vld is low.
- R9: A configuration write made in the same cycle as a strobe, or later, does not change that lookup's result. It takes effect from the next lookup.
- R10: After reset, every valid flag and every table bit is 0, so any address other than broadcast is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration word address (entry or table word) |
| cfg_wr_data | input | 32 | Configuration write data |
| mc_type | input | 2 | Hash window selection |
| lk_stb | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address to judge |
| res_vld | output | 1 | Lookup result valid, two cycles after the strobe |
| res_acc | output | 1 | Accept decision, qualified by res_vld |

## Verification
The bench flips the top address bit against a stored entry. A filter that compared only part of the address would accept that address. It also disables an entry by its high word alone while the low word still holds the address, which catches a design that qualifies matches wrongly. For each of the four hash windows it sets only the predicted table bit and then only its neighbour. A wrong slice or a swapped word/bit split shows up as a missed or false accept. The bench also sets a table bit for a unicast address, which a design that ignored the group bit would accept. Writes issued in the same cycle as a strobe must leave that lookup unchanged and affect the next one; a design that sampled the tables late would give the new answer too early.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    parameter int MAC_W     = 48;
    parameter int N_ENTRY   = 16;
    parameter int HASH_W    = 12;
    parameter int WORD_W    = 32;
    parameter int CFG_AW    = 8;

    localparam int HT_WORDS = (1 << HASH_W) / WORD_W;
    localparam int BSEL_W   = $clog2(WORD_W);
    localparam int WSEL_W   = HASH_W - BSEL_W;
    localparam int ENT_W    = $clog2(N_ENTRY);
    localparam int HI_BYTES = MAC_W - WORD_W;
    localparam int VLD_BIT  = WORD_W - 1;

    typedef struct packed {
        logic             vld;
        logic [MAC_W-1:0] mac;
    } entry_t;

    // Pick the 12-bit hash window selected by the mode.
    function automatic logic [HASH_W-1:0] hash_pick(input logic [MAC_W-1:0] a,
                                                    input logic [1:0]       mode);
        logic [HASH_W-1:0] h;
        case (mode)
            2'd0:    h = a[47:36];
            2'd1:    h = a[46:35];
            2'd2:    h = a[45:34];
            default: h = a[43:32];
        endcase
        return h;
    endfunction

endpackage

// File: rtl/rxaf_exact_bank.sv
module rxaf_exact_bank
    import rxaf_pkg::*;
#(
    parameter int N   = N_ENTRY,
    parameter int IW  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [IW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [MAC_W-1:0]  key,
    output logic [N-1:0]      hit
);

    typedef struct packed {
        entry_t [N-1:0] ent;
    } bank_t;

    bank_t b_d, b_q;

    logic unused_mid_bits;
    assign unused_mid_bits = ^wr_data[VLD_BIT-1:HI_BYTES];

    always_comb begin
        b_d = b_q;
        if (wr_en) begin
            if (wr_hi) begin
                b_d.ent[wr_idx].vld                  = wr_data[VLD_BIT];
                b_d.ent[wr_idx].mac[MAC_W-1:WORD_W]  = wr_data[HI_BYTES-1:0];
            end else begin
                b_d.ent[wr_idx].mac[WORD_W-1:0]      = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = b_q.ent[i].vld && (b_q.ent[i].mac == key);
    end

endmodule

// File: rtl/rxaf_hash_table.sv
module rxaf_hash_table
    import rxaf_pkg::*;
#(
    parameter int WORDS = HT_WORDS,
    parameter int WW    = WORD_W,
    parameter int HW    = HASH_W,
    parameter int BW    = $clog2(WW),
    parameter int SW    = HW - BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  logic [WW-1:0] wr_data,
    input  logic [HW-1:0] rd_hash,
    output logic          rd_bit
);

    typedef struct packed {
        logic [WORDS-1:0][WW-1:0] w;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (wr_en) t_d.w[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rd_bit = t_q.w[rd_hash[HW-1:BW]][rd_hash[BW-1:0]];

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [WORD_W-1:0] cfg_wr_data,
    input  logic [1:0]        mc_type,
    input  logic              lk_stb,
    input  logic [MAC_W-1:0]  lk_addr,
    output logic              res_vld,
    output logic              res_acc
);

    localparam int RGN_BIT = CFG_AW - 1;       // 1: hash table, 0: entries
    localparam int PAD_LO  = ENT_W + 1;        // first must-be-zero bit

    typedef struct packed {
        logic s1_vld;
        logic s1_exact;
        logic s1_mc;
        logic s1_bc;
        logic s2_vld;
        logic s2_acc;
    } pipe_t;

    pipe_t p_d, p_q;

    logic               ent_we, ht_we;
    logic [N_ENTRY-1:0] ent_hit;
    logic [HASH_W-1:0]  lk_hash;
    logic               ht_bit;

    assign ent_we  = cfg_wr_en && !cfg_wr_addr[RGN_BIT]
                     && (cfg_wr_addr[RGN_BIT-1:PAD_LO] == '0);
    assign ht_we   = cfg_wr_en && cfg_wr_addr[RGN_BIT];
    assign lk_hash = hash_pick(lk_addr, mc_type);

    rxaf_exact_bank #(.N(N_ENTRY)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ent_we),
        .wr_hi   (cfg_wr_addr[0]),
        .wr_idx  (cfg_wr_addr[ENT_W:1]),
        .wr_data (cfg_wr_data),
        .key     (lk_addr),
        .hit     (ent_hit)
    );

    rxaf_hash_table #(.WORDS(HT_WORDS), .WW(WORD_W), .HW(HASH_W)) u_hash (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ht_we),
        .wr_idx  (cfg_wr_addr[WSEL_W-1:0]),
        .wr_data (cfg_wr_data),
        .rd_hash (lk_hash),
        .rd_bit  (ht_bit)
    );

    // Stage 1 samples the tables in the strobe cycle; stage 2 combines.
    always_comb begin
        p_d        = p_q;
        p_d.s1_vld = lk_stb;
        if (lk_stb) begin
            p_d.s1_exact = |ent_hit;
            p_d.s1_mc    = lk_addr[0] && ht_bit;
            p_d.s1_bc    = &lk_addr;
        end
        p_d.s2_vld = p_q.s1_vld;
        p_d.s2_acc = p_q.s1_vld && (p_q.s1_exact || p_q.s1_mc || p_q.s1_bc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign res_vld = p_q.s2_vld;
    assign res_acc = p_q.s2_acc;

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker
    import rxaf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_stb,
    input logic [MAC_W-1:0] lk_addr,
    input logic             res_vld,
    input logic             res_acc
);

    // R8: every strobe yields a result two edges later
    a_r8_vld_follows_stb: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stb |-> ##2 res_vld);

    // R8: no result without a strobe two cycles earlier
    a_r8_no_stray_vld: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(lk_stb, 2));

    // R8: accept is qualified by valid
    a_r8_acc_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        res_acc |-> res_vld);

    // R7: broadcast always accepted
    a_r7_bcast_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_stb && (&lk_addr)) |-> ##2 res_acc);

endmodule

bind rx_addr_filter rxaf_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_stb  (lk_stb),
    .lk_addr (lk_addr),
    .res_vld (res_vld),
    .res_acc (res_acc)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [1:0]  mc_type = '0;
    logic        lk_stb = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        res_vld, res_acc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .mc_type     (mc_type),
        .lk_stb      (lk_stb),
        .lk_addr     (lk_addr),
        .res_vld     (res_vld),
        .res_acc     (res_acc)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_entry(input int idx, input logic [47:0] m, input bit v);
        wr({3'b000, idx[3:0], 1'b0}, m[31:0]);
        wr({3'b000, idx[3:0], 1'b1}, {v, 15'd0, m[47:32]});
    endtask

    // Strobe, optionally with a concurrent write; sample after the second edge.
    task automatic lookup_w(input logic [47:0] a, input bit do_wr,
                            input logic [7:0] wa, input logic [31:0] wd,
                            output bit acc);
        @(negedge clk);
        lk_stb = 1'b1; lk_addr = a;
        if (do_wr) begin
            cfg_wr_en = 1'b1; cfg_wr_addr = wa; cfg_wr_data = wd;
        end
        @(negedge clk);
        lk_stb = 1'b0; cfg_wr_en = 1'b0;
        @(negedge clk);
        check(res_vld === 1'b1, "R8 vld at result slot", int'(res_vld), 1);
        acc = res_acc;
    endtask

    task automatic lookup(input logic [47:0] a, output bit acc);
        lookup_w(a, 1'b0, 8'h00, 32'h0, acc);
    endtask

    task automatic t_reset();
        bit acc;
        check(res_vld === 1'b0 && res_acc === 1'b0, "R10 outputs idle", int'(res_vld), 0);
        lookup(48'h0000_5634_1200, acc);
        check(acc == 1'b0, "R10 unicast rejected after reset", int'(acc), 0);
        lookup(48'hFFFF_FFFF_FF01 ^ 48'h8000_0000_0000, acc);
        check(acc == 1'b0, "R10 multicast rejected after reset", int'(acc), 0);
    endtask

    task automatic t_exact();
        bit acc;
        logic [47:0] ma = 48'h0A1B_2C3D_4E50;
        logic [47:0] mb = 48'h6655_4433_2210;
        logic [47:0] mc = 48'h1234_5678_9AB0;
        logic [47:0] md = 48'h0F0E_0D0C_0B0A;
        set_entry(0, ma, 1'b1);
        lookup(ma, acc);
        check(acc == 1'b1, "R1 R2 entry 0 match", int'(acc), 1);
        lookup(ma ^ 48'h8000_0000_0000, acc);
        check(acc == 1'b0, "R2 top bit differs", int'(acc), 0);
        lookup(ma ^ 48'h0000_0000_0100, acc);
        check(acc == 1'b0, "R2 byte 1 differs", int'(acc), 0);
        set_entry(15, mb, 1'b1);
        lookup(mb, acc);
        check(acc == 1'b1, "R2 entry 15 match", int'(acc), 1);
        set_entry(7, mc, 1'b0);
        lookup(mc, acc);
        check(acc == 1'b0, "R2 invalid entry no match", int'(acc), 0);
        wr(8'b0110_0100, md[31:0]);
        wr(8'b0110_0101, {1'b1, 15'd0, md[47:32]});
        lookup(md, acc);
        check(acc == 1'b0, "R1 nonzero pad bits ignored", int'(acc), 0);
    endtask

    task automatic t_clear();
        bit acc;
        logic [47:0] mb = 48'h6655_4433_2210;
        wr({3'b000, 4'd15, 1'b1}, 32'h0);
        lookup(mb, acc);
        check(acc == 1'b0, "R3 high word clear disables", int'(acc), 0);
        wr({3'b000, 4'd15, 1'b0}, 32'h0);
        lookup(mb, acc);
        check(acc == 1'b0, "R3 fully cleared", int'(acc), 0);
    endtask

    task automatic t_hash();
        bit acc;
        logic [47:0] m = 48'h5635_0000_0001;
        int sh[4] = '{36, 35, 34, 32};
        mc_type = 2'd0;
        wr(8'h80 | 8'h2B, 32'h0000_0008);
        lookup(m, acc);
        check(acc == 1'b1, "R5 mode 0 hash 0x563", int'(acc), 1);
        wr(8'h80 | 8'h2B, 32'h0);
        lookup(m, acc);
        check(acc == 1'b0, "R4 word cleared", int'(acc), 0);
        for (int t = 0; t < 4; t++) begin
            logic [11:0] h;
            logic [11:0] hn;
            h  = 12'((m >> sh[t]) & 48'hFFF);
            hn = h ^ 12'h001;
            mc_type = 2'(t);
            wr({1'b1, h[11:5]}, 32'h1 << h[4:0]);
            lookup(m, acc);
            check(acc == 1'b1, $sformatf("R4 R5 mode %0d selected bit", t), int'(acc), 1);
            wr({1'b1, h[11:5]}, 32'h0);
            wr({1'b1, hn[11:5]}, 32'h1 << hn[4:0]);
            lookup(m, acc);
            check(acc == 1'b0, $sformatf("R5 mode %0d neighbour bit", t), int'(acc), 0);
            wr({1'b1, hn[11:5]}, 32'h0);
        end
    endtask

    task automatic t_unicast();
        bit acc;
        logic [47:0] u = 48'h5635_0000_0000;
        mc_type = 2'd0;
        wr(8'h80 | 8'h2B, 32'h0000_0008);
        lookup(u, acc);
        check(acc == 1'b0, "R6 unicast ignores table", int'(acc), 0);
        lookup(u | 48'h1, acc);
        check(acc == 1'b1, "R6 same address as multicast", int'(acc), 1);
        wr(8'h80 | 8'h2B, 32'h0);
    endtask

    task automatic t_bcast();
        bit acc;
        for (int t = 0; t < 4; t++) begin
            mc_type = 2'(t);
            lookup(48'hFFFF_FFFF_FFFF, acc);
            check(acc == 1'b1, "R7 broadcast kept", int'(acc), 1);
        end
    endtask

    task automatic t_latency();
        @(negedge clk);
        lk_stb = 1'b1; lk_addr = 48'hFFFF_FFFF_FFFF;
        @(negedge clk);
        lk_stb = 1'b0;
        check(res_vld === 1'b0, "R8 not yet after one edge", int'(res_vld), 0);
        @(negedge clk);
        check(res_vld === 1'b1 && res_acc === 1'b1, "R8 result after two edges", int'(res_vld), 1);
        @(negedge clk);
        check(res_vld === 1'b0 && res_acc === 1'b0, "R8 single-cycle pulse", int'(res_vld), 0);
    endtask

    task automatic t_write_during();
        bit acc;
        logic [47:0] me = 48'h00AA_BBCC_DD02;
        set_entry(3, me, 1'b1);
        lookup_w(me, 1'b1, {3'b000, 4'd3, 1'b1}, {1'b0, 15'd0, me[47:32]}, acc);
        check(acc == 1'b1, "R9 disable in strobe cycle not seen", int'(acc), 1);
        lookup(me, acc);
        check(acc == 1'b0, "R9 disable seen next lookup", int'(acc), 0);
        lookup_w(me, 1'b1, {3'b000, 4'd3, 1'b1}, {1'b1, 15'd0, me[47:32]}, acc);
        check(acc == 1'b0, "R9 enable in strobe cycle not seen", int'(acc), 0);
        lookup(me, acc);
        check(acc == 1'b1, "R9 enable seen next lookup", int'(acc), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_clear();
        t_hash();
        t_unicast();
        t_bcast();
        t_latency();
        t_write_during();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (WDOG_CYC) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule